// File: doc/BRIEF.md
# Flag-Setting Subtract Execution Unit

This unit carries out the three register-operand variants of a flag-setting integer subtract. It accepts one 32-bit instruction word per cycle, together with the first-source register value, the second-source register value and the current stack pointer. It works out which variant the word encodes: extended register, immediate, or shifted register. It then forms the second operand, subtracts it from the first, and returns the difference with four condition flags and the destination register index.

The subtract is done as an add of the inverted second operand with a carry-in of one. The carry flag therefore means "no borrow". A size bit in the word selects 64-bit or 32-bit operation. In 32-bit operation only the low halves take part, and the difference is zero-extended into the 64-bit result port. Outputs are registered, so each word gives its answer one clock later. Words that are not one of the recognised encodings, or that use a reserved field value, are flagged as unallocated.

Top module: `subs_unit`

## Requirements
- R1: While reset is high and on the first sampling after it, out_valid, out_err, out_result, out_nzcv and out_rd are all zero.
- R2: Results appear one clock after the word is accepted. out_valid is in_valid delayed by one cycle, and out_rd carries instruction bits [4:0] for an allocated word.
- R3: Bits [31:21] equal to s,1,1,0,1,0,1,1,0,0,1 (where s is bit 31) select the extended form. The second source value is taken at a width given by bits [14:13]: 0 byte, 1 halfword, 2 word, 3 doubleword. It is zero-extended when bit 15 is 0 and sign-extended when bit 15 is 1.
- R4: In the extended form the extended operand is shifted left by bits [12:10]. A shift value of 5, 6 or 7 makes the word unallocated.
- R5: First-source index 31 (bits [9:5]) selects sp_val in the extended and immediate forms. In the shifted form it selects zero. Any other index selects rn_val.
- R6: Bits [30:23] equal to 1,1,1,0,0,0,1,0 select the immediate form. The operand is bits [21:10], shifted left by 12 when bit 22 is set.
- R7: Bits [30:24] equal to 1,1,0,1,0,1,1 with bit 21 clear select the shifted form. Bits [23:22] pick the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 unallocated. Bits [15:10] give the amount, and in 32-bit mode an amount of 32 or more is unallocated.
- R8: out_result is op1 plus the inverted op2 plus one, truncated to the data size. This is op1 minus op2 modulo 2^size.
- R9: out_nzcv holds N in bit 3 (sign of the result), Z in bit 2 (result is zero), C in bit 1 (carry out, meaning no borrow) and V in bit 0 (signed overflow).
- R10: Bit 31 clear selects 32-bit mode. Operands use only bits [31:0], out_result[63:32] is zero, and the flags come from the 32-bit difference.
- R11: An unallocated word gives out_err high, with out_result, out_nzcv and out_rd all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | 64 | First-source register value |
| rm_val | input | 64 | Second-source register value |
| sp_val | input | 64 | Stack pointer value |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Word was unallocated |
| out_result | output | 64 | Difference, zero-extended in 32-bit mode |
| out_nzcv | output | 4 | Flags N, Z, C, V from bit 3 down |
| out_rd | output | 5 | Destination register index |

## Verification
The properties assume that the instruction word sampled one cycle before a result belongs to that result, which holds because every output register loads on each clock. They also assume that the word and operands are two-state whenever in_valid is high. The stimulus meets both conditions. It changes every input only on the falling clock edge and gives each input a fully known value. It holds reset across several edges before the first word, so no property reaches back past reset.

// File: rtl/subs_pkg.sv
package subs_pkg;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_EXT  = 2'd1,
        FORM_IMM  = 2'd2,
        FORM_SHF  = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_RSV = 2'd3
    } shtype_e;

    localparam logic [4:0] STACK_IDX     = 5'd31;
    localparam int         EXT_SHIFT_MAX = 4;
    localparam int         IMM_HI_SHIFT  = 12;

    typedef struct packed {
        form_e       form;
        logic        wide;
        logic [4:0]  rn;
        logic [4:0]  rd;
        logic [2:0]  opt;
        logic [5:0]  amt;
        shtype_e     sht;
        logic [11:0] imm12;
        logic        imm_hi;
        logic        unalloc;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/subs_decode.sv
module subs_decode
    import subs_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    always_comb begin
        dec        = '0;
        dec.form   = FORM_NONE;
        dec.wide   = instr[31];
        dec.rn     = instr[9:5];
        dec.rd     = instr[4:0];
        dec.opt    = instr[15:13];
        dec.sht    = shtype_e'(instr[23:22]);
        dec.imm12  = instr[21:10];
        dec.imm_hi = instr[22];
        if (instr[30:29] == 2'b11) begin
            if (instr[28:23] == 6'b100010) begin
                dec.form = FORM_IMM;
            end else if (instr[28:24] == 5'b01011) begin
                if (instr[21]) begin
                    if (instr[23:22] == 2'b00) begin
                        dec.form = FORM_EXT;
                        dec.amt  = {3'b000, instr[12:10]};
                    end
                end else begin
                    dec.form = FORM_SHF;
                    dec.amt  = instr[15:10];
                end
            end
        end
        unique case (dec.form)
            FORM_NONE: dec.unalloc = 1'b1;
            FORM_EXT:  dec.unalloc = (int'(dec.amt) > EXT_SHIFT_MAX);
            FORM_SHF:  dec.unalloc = (dec.sht == SH_RSV) || (!dec.wide && dec.amt[5]);
            default:   dec.unalloc = 1'b0;
        endcase
    end
endmodule

// File: rtl/subs_operands.sv
module subs_operands
    import subs_pkg::*;
#(
    parameter int DW = 64
) (
    input  dec_t          dec,
    input  logic [DW-1:0] rn_val,
    input  logic [DW-1:0] rm_val,
    input  logic [DW-1:0] sp_val,
    output logic [DW-1:0] op1,
    output logic [DW-1:0] op2
);
    localparam int HW = DW / 2;

    logic [DW-1:0] ext_v;
    logic [DW-1:0] ext_sh;
    logic [DW-1:0] imm_v;
    logic [DW-1:0] shf_w;
    logic [HW-1:0] shf_n;
    logic [DW-1:0] base1;
    logic [DW-1:0] base2;
    logic          sgn;

    // operand 2, extended form
    always_comb begin
        sgn = dec.opt[2];
        unique case (dec.opt[1:0])
            2'd0:    ext_v = {{(DW-8){sgn & rm_val[7]}}, rm_val[7:0]};
            2'd1:    ext_v = {{(DW-16){sgn & rm_val[15]}}, rm_val[15:0]};
            2'd2:    ext_v = {{(DW-HW){sgn & rm_val[HW-1]}}, rm_val[HW-1:0]};
            default: ext_v = rm_val;
        endcase
        ext_sh = ext_v << dec.amt[2:0];
    end

    // operand 2, immediate form
    always_comb begin
        imm_v = {{(DW-12){1'b0}}, dec.imm12};
        if (dec.imm_hi) imm_v = imm_v << IMM_HI_SHIFT;
    end

    // operand 2, shifted form, both widths
    always_comb begin
        unique case (dec.sht)
            SH_LSL:  shf_w = rm_val << dec.amt;
            SH_LSR:  shf_w = rm_val >> dec.amt;
            SH_ASR:  shf_w = DW'($signed(rm_val) >>> dec.amt);
            default: shf_w = '0;
        endcase
        unique case (dec.sht)
            SH_LSL:  shf_n = rm_val[HW-1:0] << dec.amt[4:0];
            SH_LSR:  shf_n = rm_val[HW-1:0] >> dec.amt[4:0];
            SH_ASR:  shf_n = HW'($signed(rm_val[HW-1:0]) >>> dec.amt[4:0]);
            default: shf_n = '0;
        endcase
    end

    always_comb begin
        unique case (dec.form)
            FORM_EXT: base2 = ext_sh;
            FORM_IMM: base2 = imm_v;
            FORM_SHF: base2 = dec.wide ? shf_w : {{(DW-HW){1'b0}}, shf_n};
            default:  base2 = '0;
        endcase
        if (dec.rn == STACK_IDX) begin
            base1 = (dec.form == FORM_SHF) ? '0 : sp_val;
        end else begin
            base1 = rn_val;
        end
        if (dec.wide) begin
            op1 = base1;
            op2 = base2;
        end else begin
            op1 = {{(DW-HW){1'b0}}, base1[HW-1:0]};
            op2 = {{(DW-HW){1'b0}}, base2[HW-1:0]};
        end
    end
endmodule

// File: rtl/subs_addc.sv
module subs_addc
    import subs_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output nzcv_t        flags
);
    logic [W:0] sum;

    always_comb begin
        sum     = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        res     = sum[W-1:0];
        flags.n = sum[W-1];
        flags.z = (sum[W-1:0] == '0);
        flags.c = sum[W];
        flags.v = (a[W-1] ^ b[W-1]) & (sum[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/subs_unit.sv
module subs_unit
    import subs_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   instr,
    input  logic [DW-1:0] rn_val,
    input  logic [DW-1:0] rm_val,
    input  logic [DW-1:0] sp_val,
    output logic          out_valid,
    output logic          out_err,
    output logic [DW-1:0] out_result,
    output logic [3:0]    out_nzcv,
    output logic [4:0]    out_rd
);
    localparam int HW = DW / 2;

    dec_t          dec;
    logic [DW-1:0] op1;
    logic [DW-1:0] op2;
    logic [DW-1:0] res_w;
    logic [HW-1:0] res_n;
    nzcv_t         fl_w;
    nzcv_t         fl_n;
    logic [DW-1:0] res_sel;
    nzcv_t         fl_sel;

    subs_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    subs_operands #(.DW(DW)) u_ops (
        .dec    (dec),
        .rn_val (rn_val),
        .rm_val (rm_val),
        .sp_val (sp_val),
        .op1    (op1),
        .op2    (op2)
    );

    subs_addc #(.W(DW)) u_add_wide (
        .a     (op1),
        .b     (op2),
        .res   (res_w),
        .flags (fl_w)
    );

    subs_addc #(.W(HW)) u_add_narrow (
        .a     (op1[HW-1:0]),
        .b     (op2[HW-1:0]),
        .res   (res_n),
        .flags (fl_n)
    );

    always_comb begin
        if (dec.wide) begin
            res_sel = res_w;
            fl_sel  = fl_w;
        end else begin
            res_sel = {{(DW-HW){1'b0}}, res_n};
            fl_sel  = fl_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_result <= '0;
            out_nzcv   <= '0;
            out_rd     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && !dec.unalloc) begin
                out_err    <= 1'b0;
                out_result <= res_sel;
                out_nzcv   <= fl_sel;
                out_rd     <= dec.rd;
            end else begin
                out_err    <= in_valid;
                out_result <= '0;
                out_nzcv   <= '0;
                out_rd     <= '0;
            end
        end
    end
endmodule

// File: rtl/subs_unit_chk.sv
module subs_unit_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [31:0]   instr,
    input logic          out_valid,
    input logic          out_err,
    input logic [DW-1:0] out_result,
    input logic [3:0]    out_nzcv,
    input logic [4:0]    out_rd
);
    localparam int HW = DW / 2;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !out_valid && !out_err);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_dest_index_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_err |-> out_rd == $past(instr[4:0]));

    assert_err_only_valid_R11: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_result == '0 && out_nzcv == 4'd0 && out_rd == 5'd0);

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_err |-> out_nzcv[2] == (out_result == '0));

    assert_neg_flag_wide_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_err && $past(instr[31]) |-> out_nzcv[3] == out_result[DW-1]);

    assert_upper_clear_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_err && !$past(instr[31]) |->
            out_result[DW-1:HW] == '0 && out_nzcv[3] == out_result[HW-1]);
endmodule

bind subs_unit subs_unit_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_result (out_result),
    .out_nzcv   (out_nzcv),
    .out_rd     (out_rd)
);

// File: tb/subs_unit_tb.sv
`timescale 1ns/1ps
module subs_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rn_val = '0;
    logic [63:0] rm_val = '0;
    logic [63:0] sp_val = '0;
    logic        out_valid;
    logic        out_err;
    logic [63:0] out_result;
    logic [3:0]  out_nzcv;
    logic [4:0]  out_rd;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    subs_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .rn_val(rn_val), .rm_val(rm_val), .sp_val(sp_val),
        .out_valid(out_valid), .out_err(out_err), .out_result(out_result),
        .out_nzcv(out_nzcv), .out_rd(out_rd)
    );

    // form: 0 raw zero word, 1 extended, 2 immediate, 3 shifted
    typedef struct packed {
        logic [1:0]  form;
        logic        sf;
        logic [2:0]  fa;
        logic [11:0] fb;
        logic [4:0]  rn;
        logic [4:0]  rd;
        logic [63:0] rnv;
        logic [63:0] rmv;
        logic [63:0] spv;
        logic        err;
        logic [63:0] res;
        logic [3:0]  nzcv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        // R3 R8 doubleword zero-extend
        '{2'd1,1'b1,3'b011,12'd0,5'd1,5'd3,64'd10,64'd3,64'd0,1'b0,64'd7,4'b0010,8'd3},
        // R3 byte zero-extend
        '{2'd1,1'b1,3'b000,12'd0,5'd1,5'd4,64'h100,64'hFFFF_FF80,64'd0,1'b0,64'h80,4'b0010,8'd3},
        // R3 R9 byte sign-extend, borrow
        '{2'd1,1'b1,3'b100,12'd0,5'd1,5'd5,64'd0,64'h80,64'd0,1'b0,64'h80,4'b0000,8'd3},
        // R4 halfword sign-extend shifted by 4
        '{2'd1,1'b1,3'b101,12'd4,5'd1,5'd6,64'd0,64'h8000,64'd0,1'b0,64'h8_0000,4'b0000,8'd4},
        // R4 R9 word zero-extend shift 2, zero result
        '{2'd1,1'b1,3'b010,12'd2,5'd1,5'd7,64'h1_0000_0000,64'hFFFF_FFFF_4000_0000,64'd0,1'b0,64'd0,4'b0110,8'd4},
        // R3 word sign-extend shift 1
        '{2'd1,1'b1,3'b110,12'd1,5'd1,5'd8,64'd5,64'h8000_0000,64'd0,1'b0,64'h1_0000_0005,4'b0000,8'd3},
        // R4 shift 5 unallocated
        '{2'd1,1'b1,3'b011,12'd5,5'd1,5'd9,64'd9,64'd1,64'd0,1'b1,64'd0,4'b0000,8'd4},
        // R5 index 31 is stack pointer
        '{2'd1,1'b1,3'b011,12'd0,5'd31,5'd10,64'hDEAD,64'h10,64'h1000,1'b0,64'hFF0,4'b0010,8'd5},
        // R10 32-bit wrap, upper input ignored
        '{2'd1,1'b0,3'b011,12'd0,5'd1,5'd11,64'hFFFF_FFFF_0000_0000,64'd1,64'd0,1'b0,64'hFFFF_FFFF,4'b1000,8'd10},
        // R9 R10 32-bit signed overflow
        '{2'd1,1'b0,3'b010,12'd0,5'd1,5'd12,64'h8000_0000,64'd1,64'd0,1'b0,64'h7FFF_FFFF,4'b0011,8'd9},
        // R9 64-bit signed overflow
        '{2'd1,1'b1,3'b011,12'd0,5'd1,5'd13,64'h8000_0000_0000_0000,64'd1,64'd0,1'b0,64'h7FFF_FFFF_FFFF_FFFF,4'b0011,8'd9},
        // R5 R10 stack pointer truncated in 32-bit mode
        '{2'd1,1'b0,3'b011,12'd0,5'd31,5'd14,64'd7,64'h10,64'hAAAA_AAAA_0000_0010,1'b0,64'd0,4'b0110,8'd5},
        // R6 immediate unshifted
        '{2'd2,1'b1,3'b000,12'hFFF,5'd1,5'd15,64'h1000,64'd0,64'd0,1'b0,64'd1,4'b0010,8'd6},
        // R6 immediate shifted by 12
        '{2'd2,1'b1,3'b001,12'd1,5'd1,5'd16,64'h1000,64'd0,64'd0,1'b0,64'd0,4'b0110,8'd6},
        // R5 R6 immediate, stack pointer, 32-bit
        '{2'd2,1'b0,3'b000,12'h21,5'd31,5'd17,64'd0,64'd0,64'h20,1'b0,64'hFFFF_FFFF,4'b1000,8'd6},
        // R7 logical left
        '{2'd3,1'b1,3'b000,12'd8,5'd1,5'd18,64'h1000,64'h10,64'd0,1'b0,64'd0,4'b0110,8'd7},
        // R7 logical right
        '{2'd3,1'b1,3'b001,12'd4,5'd1,5'd19,64'h100,64'h100,64'd0,1'b0,64'hF0,4'b0010,8'd7},
        // R7 R10 arithmetic right in 32-bit mode
        '{2'd3,1'b0,3'b010,12'd4,5'd1,5'd20,64'd0,64'h8000_0000,64'd0,1'b0,64'h0800_0000,4'b0000,8'd7},
        // R7 shift type 3 unallocated
        '{2'd3,1'b1,3'b011,12'd1,5'd1,5'd21,64'd4,64'd1,64'd0,1'b1,64'd0,4'b0000,8'd7},
        // R7 32-bit amount 32 unallocated
        '{2'd3,1'b0,3'b000,12'd32,5'd1,5'd22,64'd4,64'd1,64'd0,1'b1,64'd0,4'b0000,8'd7},
        // R5 shifted form index 31 is zero
        '{2'd3,1'b1,3'b000,12'd0,5'd31,5'd23,64'd9,64'd1,64'h55,1'b0,64'hFFFF_FFFF_FFFF_FFFF,4'b1000,8'd5},
        // R11 unrecognised word
        '{2'd0,1'b0,3'b000,12'd0,5'd0,5'd0,64'd1,64'd1,64'd1,1'b1,64'd0,4'b0000,8'd11},
        // R3 doubleword sign-extend
        '{2'd1,1'b1,3'b111,12'd0,5'd1,5'd24,64'd3,64'd5,64'd0,1'b0,64'hFFFF_FFFF_FFFF_FFFE,4'b1000,8'd3},
        // R3 halfword zero-extend
        '{2'd1,1'b1,3'b001,12'd0,5'd1,5'd25,64'h1_0000,64'hABCD_1234,64'd0,1'b0,64'hEDCC,4'b0010,8'd3}
    };

    function automatic logic [31:0] build(vec_t v);
        case (v.form)
            2'd1:    return {v.sf, 2'b11, 5'b01011, 2'b00, 1'b1, 5'd2, v.fa, v.fb[2:0], v.rn, v.rd};
            2'd2:    return {v.sf, 2'b11, 6'b100010, v.fa[0], v.fb, v.rn, v.rd};
            2'd3:    return {v.sf, 2'b11, 5'b01011, v.fa[1:0], 1'b0, 5'd2, v.fb[5:0], v.rn, v.rd};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // reset held with a word present: R1
        in_valid = 1'b1;
        instr = 32'hEB22_0C22;
        rn_val = 64'd50;
        rm_val = 64'd5;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 64'd0);
        check(out_result == '0 && out_nzcv == 4'd0 && out_rd == 5'd0 && !out_err,
              "R1", "outputs in reset", out_result, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            instr = build(VECS[i]);
            rn_val = VECS[i].rnv;
            rm_val = VECS[i].rmv;
            sp_val = VECS[i].spv;
            in_valid = 1'b1;
            @(negedge clk);
            check(out_valid == 1'b1, "R2", "valid latency", 64'(out_valid), 64'd1);
            check(out_err == VECS[i].err, tag, "err", 64'(out_err), 64'(VECS[i].err));
            check(out_result == VECS[i].res, tag, "result", out_result, VECS[i].res);
            check(out_nzcv == VECS[i].nzcv, tag, "nzcv", 64'(out_nzcv), 64'(VECS[i].nzcv));
            check(out_rd == (VECS[i].err ? 5'd0 : VECS[i].rd), "R2 R11", "rd",
                  64'(out_rd), 64'(VECS[i].err ? 5'd0 : VECS[i].rd));
        end

        // R2: gap in valid gives gap in output
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "idle valid", 64'(out_valid), 64'd0);

        // R8: wraparound 0 - 1 in 64-bit mode, extended form
        instr = {1'b1, 2'b11, 5'b01011, 2'b00, 1'b1, 5'd2, 3'b011, 3'd0, 5'd1, 5'd30};
        rn_val = 64'd0;
        rm_val = 64'd1;
        in_valid = 1'b1;
        @(negedge clk);
        check(out_result == 64'hFFFF_FFFF_FFFF_FFFF, "R8", "wrap result", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
        check(out_nzcv == 4'b1000, "R9", "wrap flags", 64'(out_nzcv), 64'b1000);

        // R1: reset mid-stream clears outputs
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_result == '0, "R1", "mid reset", out_result, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule